// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block implements a two-address, byte-wide configuration port. Both addresses are decoded from a narrow I/O bus. The index port sits at a strap-selected base address, and the data port sits at the next address up. Software first writes an index byte to the index port. It then reads or writes the data port to reach the register that the index names. Access starts locked. Software opens it by writing the key byte 0x87 to the index port twice in a row, and closes it again by writing 0xAA to the index port.

A small set of global registers lives in the block itself:

- a logical-device select register;
- a read-only identifier byte;
- one activate bit per logical device, reached through the selected device's window.

Indices above the activate register are passed to downstream device logic over a plain read/write strobe interface. That interface carries the index, the write data and the selected device number, and takes back a read byte in the same cycle. Bus read data is registered and appears one clock after the read strobe.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The index port is at the base address and the data port is at base+1. The base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Any other address reads 0xFF.
- R2: The interface opens only after two back-to-back index-port writes of 0x87. Any other index byte written while locked restarts the key count.
- R3: While open, writing 0xAA to the index port locks the interface. The index latch keeps its value, and that write does not load it.
- R4: While locked, reads of either port return 0xFF.
- R5: While locked, data-port writes are ignored: no register changes and no downstream strobe fires.
- R6: After reset the interface is locked, the index latch and device select are 0, every activate bit is 0, and `bus_rdata` is 0xFF.
- R7: Index 0x07 is the read/write logical-device select. Its low bits drive `dev_sel`.
- R8: Index 0x20 reads the `CHIP_ID` parameter (default 0x5A). Writes to it are ignored.
- R9: Bit 0 of index 0x30 is the activate bit of the selected device. Bits 7:1 read as 0. Each device keeps its own bit, and a select value of NDEV or more reads 0 and changes no bit.
- R10: Data-port accesses at indices above 0x30 assert `dev_wr`/`dev_rd` in the same cycle, with `dev_idx` and `dev_wdata`. A read returns `dev_rdata`. Other undecoded indices below 0x30 read 0x00 and ignore writes.
- R11: `bus_rdata` is loaded on the clock edge that samples `bus_rd`. A read and a write in the same cycle return the state before that write.
- R12: While open, an index-port read returns the index latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| bus_addr | input | AW | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | High while configuration access is unlocked |
| dev_sel | output | LDW | Selected logical device |
| dev_active | output | NDEV | Activate bit of every device |
| dev_wr | output | 1 | Downstream register write strobe |
| dev_rd | output | 1 | Downstream register read strobe |
| dev_idx | output | 8 | Downstream register index |
| dev_wdata | output | 8 | Downstream write byte |
| dev_rdata | input | 8 | Downstream read byte, valid in the `dev_rd` cycle |

## Verification
Two functions can land in the same cycle: a port read and a port write. The critical case is a read of the index port combined with a write of the lock byte to the same port. The bench raises `bus_rd` and `bus_wr` together on the index port with 0xAA while the interface is open. It expects the pre-write index latch in `bus_rdata`, and `cfg_open` low afterwards. The bench also runs key sequences broken by a foreign byte, then shows through later reads that locked writes left the select register and the activate bits untouched.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_BYTE   = 8'h87;
  localparam logic [7:0] LOCK_BYTE  = 8'hAA;
  localparam logic [7:0] IDX_LDSEL  = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } key_st_t;
endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  key_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_LOCKED;
    end else if (idx_wr) begin
      case (st_q)
        ST_LOCKED: st_q <= (wdata == KEY_BYTE) ? ST_HALF : ST_LOCKED;
        ST_HALF:   st_q <= (wdata == KEY_BYTE) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   if (wdata == LOCK_BYTE) st_q <= ST_LOCKED;
        default:   st_q <= ST_LOCKED;
      endcase
    end
  end

  assign open = (st_q == ST_OPEN);
endmodule

// File: rtl/cfg_glb_regs.sv
module cfg_glb_regs
  import cfg_port_pkg::*;
#(
  parameter int NDEV = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [7:0]      idx,
  input  logic [7:0]      wdata,
  output logic [7:0]      ldsel,
  output logic [NDEV-1:0] act,
  output logic            act_sel
);
  always_ff @(posedge clk) begin
    if (rst) ldsel <= '0;
    else if (wr && idx == IDX_LDSEL) ldsel <= wdata;
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_act
    always_ff @(posedge clk) begin
      if (rst) act[g] <= 1'b0;
      else if (wr && idx == IDX_ACT && ldsel == 8'(g)) act[g] <= wdata[0];
    end
  end

  always_comb begin
    act_sel = 1'b0;
    for (int i = 0; i < NDEV; i++)
      if (ldsel == 8'(i)) act_sel = act[i];
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          NDEV    = 12,
  parameter logic [7:0]  CHIP_ID = 8'h5A,
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E,
  localparam int         LDW     = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_sel,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            cfg_open,
  output logic [LDW-1:0]  dev_sel,
  output logic [NDEV-1:0] dev_active,
  output logic            dev_wr,
  output logic            dev_rd,
  output logic [7:0]      dev_idx,
  output logic [7:0]      dev_wdata,
  input  logic [7:0]      dev_rdata
);
  logic [AW-1:0] base_a, data_a;
  logic          hit_idx, hit_dat, idx_wr, dat_wr, dat_rd, in_win, act_sel;
  logic [7:0]    idx_q, ldsel, rd_val;

  assign base_a  = base_sel ? AW'(BASE_HI) : AW'(BASE_LO);
  assign data_a  = base_a + AW'(1);
  assign hit_idx = (bus_addr == base_a);
  assign hit_dat = (bus_addr == data_a);
  assign idx_wr  = bus_wr & hit_idx;
  assign dat_wr  = bus_wr & hit_dat & cfg_open;
  assign dat_rd  = bus_rd & hit_dat & cfg_open;

  cfg_key_seq u_key (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(bus_wdata), .open(cfg_open)
  );

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (idx_wr && cfg_open && bus_wdata != LOCK_BYTE) idx_q <= bus_wdata;
  end

  cfg_glb_regs #(.NDEV(NDEV)) u_glb (
    .clk(clk), .rst(rst), .wr(dat_wr), .idx(idx_q), .wdata(bus_wdata),
    .ldsel(ldsel), .act(dev_active), .act_sel(act_sel)
  );

  assign in_win    = (idx_q > IDX_ACT);
  assign dev_wr    = dat_wr & in_win;
  assign dev_rd    = dat_rd & in_win;
  assign dev_idx   = idx_q;
  assign dev_wdata = bus_wdata;
  assign dev_sel   = ldsel[LDW-1:0];

  always_comb begin
    rd_val = IDLE_BYTE;
    if (cfg_open && hit_idx) begin
      rd_val = idx_q;
    end else if (cfg_open && hit_dat) begin
      case (idx_q)
        IDX_LDSEL:  rd_val = ldsel;
        IDX_CHIPID: rd_val = CHIP_ID;
        IDX_ACT:    rd_val = {7'b0, act_sel};
        default:    rd_val = in_win ? dev_rdata : 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= IDLE_BYTE;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int          AW      = 16,
  parameter int          NDEV    = 12,
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E,
  localparam int         LDW     = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            base_sel,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      bus_rdata,
  input logic            cfg_open,
  input logic [LDW-1:0]  dev_sel,
  input logic [NDEV-1:0] dev_active,
  input logic            dev_wr,
  input logic            dev_rd
);
  logic [AW-1:0] base_a;
  assign base_a = base_sel ? AW'(BASE_HI) : AW'(BASE_LO);

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !cfg_open) |=> (bus_rdata == 8'hFF)); // R4
  AST_NO_STROBE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |-> !(dev_wr || dev_rd)); // R5
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(bus_wr && bus_addr == base_a && bus_wdata == 8'h87)); // R2
  AST_LOCK_BYTE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_wr && bus_addr == base_a && bus_wdata == 8'hAA) |=> !cfg_open); // R3
  AST_SEL_HOLD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(dev_sel)); // R5
  AST_ACT_HOLD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(dev_active)); // R5
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
  .AW(AW), .NDEV(NDEV), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) u_chk (.*);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  localparam int AW = 16;
  localparam int NDEV = 12;
  localparam int LDW = $clog2(NDEV);
  localparam logic [1:0] IW = 2'd0, DW = 2'd1, DR = 2'd2, IR = 2'd3;
  localparam int NV = 38;
  // entry = {req[3:0], op[1:0], data[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {4'd4, DR, 8'h00, 8'hFF},   // R4 locked data read
    {4'd4, IR, 8'h00, 8'hFF},   // R4 locked index read
    {4'd2, IW, 8'h07, 8'h00},
    {4'd5, DW, 8'h03, 8'h00},   // R5 ignored
    {4'd2, IW, 8'h87, 8'h00},
    {4'd2, IW, 8'h11, 8'h00},   // R2 breaks key
    {4'd2, IW, 8'h87, 8'h00},
    {4'd2, DR, 8'h00, 8'hFF},   // R2 still locked
    {4'd2, IW, 8'h55, 8'h00},
    {4'd2, IW, 8'h87, 8'h00},
    {4'd2, IW, 8'h87, 8'h00},   // opens
    {4'd7, IW, 8'h07, 8'h00},
    {4'd5, DR, 8'h00, 8'h00},   // R5 locked write left select at 0
    {4'd12, IR, 8'h00, 8'h07},  // R12
    {4'd8, IW, 8'h20, 8'h00},
    {4'd8, DR, 8'h00, 8'h5A},   // R8
    {4'd8, DW, 8'h33, 8'h00},
    {4'd8, DR, 8'h00, 8'h5A},
    {4'd7, IW, 8'h07, 8'h00},
    {4'd7, DW, 8'h03, 8'h00},
    {4'd7, DR, 8'h00, 8'h03},   // R7
    {4'd9, IW, 8'h30, 8'h00},
    {4'd9, DW, 8'hFF, 8'h00},
    {4'd9, DR, 8'h00, 8'h01},   // R9 upper bits zero
    {4'd9, IW, 8'h07, 8'h00},
    {4'd9, DW, 8'h02, 8'h00},
    {4'd9, IW, 8'h30, 8'h00},
    {4'd9, DR, 8'h00, 8'h00},   // R9 per-device
    {4'd10, IW, 8'h10, 8'h00},
    {4'd10, DW, 8'h44, 8'h00},
    {4'd10, DR, 8'h00, 8'h00},  // R10 low index
    {4'd3, IW, 8'hAA, 8'h00},
    {4'd3, DR, 8'h00, 8'hFF},   // R3 locked again
    {4'd3, IW, 8'h87, 8'h00},
    {4'd3, IW, 8'h87, 8'h00},
    {4'd3, IR, 8'h00, 8'h10},   // R3 latch kept
    {4'd7, IW, 8'h07, 8'h00},
    {4'd7, DR, 8'h00, 8'h02}    // R7 select retained
  };

  logic clk = 1'b0, rst = 1'b1, base_sel = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, dev_idx, dev_wdata, dev_rdata;
  logic cfg_open, dev_wr, dev_rd;
  logic [LDW-1:0] dev_sel;
  logic [NDEV-1:0] dev_active;
  int errors = 0, checks = 0;
  logic rd_seen = 1'b0, wr_seen = 1'b0;
  logic [7:0] rd_idx = '0, wr_idx = '0, wr_dat = '0;

  always #10 clk = ~clk;
  assign dev_rdata = dev_idx ^ 8'hC3;

  cfg_port_ctrl u_dut (
    .clk(clk), .rst(rst), .base_sel(base_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_open(cfg_open), .dev_sel(dev_sel),
    .dev_active(dev_active), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_idx(dev_idx), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  always @(posedge clk) begin
    if (dev_rd) begin rd_seen <= 1'b1; rd_idx <= dev_idx; end
    if (dev_wr) begin wr_seen <= 1'b1; wr_idx <= dev_idx; wr_dat <= dev_wdata; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic w, input logic r,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    do_reset();
    chk("R6 open", 32'(cfg_open), 0);
    chk("R6 sel", 32'(dev_sel), 0);
    chk("R6 act", 32'(dev_active), 0);
    chk("R6 rdata", 32'(bus_rdata), 32'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      logic [15:0] a;
      v = VEC[i];
      a = (v[17:16] == IW || v[17:16] == IR) ? 16'h002E : 16'h002F;
      acc(a, v[17:16] == IW || v[17:16] == DW, v[17:16] == DR || v[17:16] == IR, v[15:8], q);
      if (v[17:16] == DR || v[17:16] == IR)
        chk($sformatf("R%0d vec %0d", v[21:18], i), 32'(q), 32'(v[7:0]));
    end
    chk("R9 act vector", 32'(dev_active), 32'h008);

    // R10 downstream window, select is 2
    acc(16'h002E, 1, 0, 8'h45, q);
    acc(16'h002F, 0, 1, 8'h00, q);
    chk("R10 read data", 32'(q), 32'(8'h45 ^ 8'hC3));
    chk("R10 rd strobe", 32'({rd_seen, rd_idx}), 32'({1'b1, 8'h45}));
    acc(16'h002F, 1, 0, 8'h61, q);
    chk("R10 wr strobe", 32'({wr_seen, wr_idx, wr_dat}), 32'({1'b1, 8'h45, 8'h61}));
    chk("R10 dev_sel", 32'(dev_sel), 2);

    // R11 read and lock write together on the index port
    acc(16'h002E, 1, 1, 8'hAA, q);
    chk("R11 old index", 32'(q), 32'h45);
    chk("R3 locked", 32'(cfg_open), 0);
    wr_seen = 1'b0;
    acc(16'h002F, 1, 0, 8'h22, q);
    chk("R5 no strobe", 32'(wr_seen), 0);

    // R1 alternate base
    base_sel = 1'b1;
    do_reset();
    acc(16'h002E, 1, 0, 8'h87, q);
    acc(16'h002E, 1, 0, 8'h87, q);
    chk("R1 old base ignored", 32'(cfg_open), 0);
    acc(16'h004E, 1, 0, 8'h87, q);
    acc(16'h004E, 1, 0, 8'h87, q);
    chk("R1 new base opens", 32'(cfg_open), 1);
    acc(16'h004E, 1, 0, 8'h20, q);
    acc(16'h004F, 0, 1, 8'h00, q);
    chk("R1 data port", 32'(q), 32'h5A);
    acc(16'h002F, 0, 1, 8'h00, q);
    chk("R1 undecoded", 32'(q), 32'hFF);
    finish_run();
  end
endmodule